// File: doc/BRIEF.md
# USB Host Frame Interval Timer

This block paces the frames of a USB host controller. Software programs a frame length in bit times and a per-frame packet budget through a small 32-bit register port. Once the controller goes operational, a 14-bit down counter steps once per bit-time strobe. When it has reached zero, the next strobe reloads it from the programmed length and raises a one-cycle start-of-frame pulse. The same reload copies the budget field into a saturating down counter. The scheduler reads that counter to decide whether a transaction still fits in the current frame.

A toggle handshake lets software see when a new frame length is actually in use. Software flips the interval toggle bit each time it writes a new length. The counter copies that bit into the remaining register when the count reaches zero. When the two toggle bits match, the new length governs the frames that follow.

The control path has two named states. HALT is entered after reset or a host-controller reset, and in it the counter is idle. RUN is the counting state. The transitions are: HALT to RUN on an operational-entry pulse; RUN to RUN (counter reload) on a repeated entry pulse; and any state to HALT on a host-controller reset.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, the interval register (address 0) reads 0x00002EDF and the remaining register (address 1) reads 0x00000000.
- R2: In HALT, bit-time strobes leave the remaining count unchanged and produce no SOF pulse.
- R3: An operational-entry pulse moves to RUN and loads the remaining count from interval bits 13:0 and the budget counter from interval bits 30:16, with no SOF pulse.
- R4: In RUN, each strobe with a nonzero count decrements the remaining count (remaining bits 13:0) by one; without a strobe the count holds.
- R5: A strobe while the count is zero reloads the count from interval bits 13:0, loads the budget from interval bits 30:16, and raises sof_pulse for exactly the one cycle after that clock edge.
- R6: The strobe that takes the count from 1 to 0 copies interval bit 31 into remaining bit 31.
- R7: A write to the interval register during a frame leaves the running count untouched; the new length is applied only at the next reload.
- R8: Writes to address 1 are ignored. Interval bits 15:14 and remaining bits 30:14 read as zero.
- R9: A host-controller reset returns to HALT, sets interval bits 13:0 to 0x2EDF, clears both toggle bits, the budget field, the remaining count and the budget counter.
- R10: The budget counter decrements on every strobe that does not reload it, and stops at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hc_reset | input | 1 | Synchronous host-controller reset |
| bit_tick | input | 1 | One-cycle strobe per USB bit time |
| op_enter | input | 1 | One-cycle pulse on entry to the operational state |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 1 | 0 selects the interval register, 1 the remaining register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| budget_cnt | output | 15 | Current largest-data-packet budget |

## Verification
The assertions assume the environment never presents two control actions in a way the priority order leaves ambiguous. Host-controller reset beats operational entry, which beats a strobe, and each counter property is guarded by the absence of the higher-priority inputs in the previous cycle. They also assume that bit strobes, entry pulses and writes are single-cycle events. The stimulus satisfies both assumptions. It drives every input on the falling clock edge and holds each one for exactly one cycle. It never overlaps a register write with a strobe, and it uses short frame lengths so that several wraps occur within the run.

// File: rtl/frm_pkg.sv
package frm_pkg;
    localparam int FR_W        = 14;
    localparam int LDP_W       = 15;
    localparam int REG_W       = 32;
    localparam int TOGGLE_BIT  = 31;
    localparam int LDP_LSB     = 16;
    localparam logic [FR_W-1:0]  FI_NOMINAL = 14'h2EDF;
    localparam logic [LDP_W-1:0] LDP_RESET  = '0;
    localparam logic ADDR_INTERVAL = 1'b0;
    localparam logic ADDR_REMAIN   = 1'b1;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } frm_state_e;
endpackage

// File: rtl/frm_regs.sv
module frm_regs
    import frm_pkg::*;
#(
    parameter int W_FR  = FR_W,
    parameter int W_LDP = LDP_W,
    parameter logic [W_FR-1:0]  FI_RST  = FI_NOMINAL,
    parameter logic [W_LDP-1:0] LDP_RST = LDP_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hc_reset,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [W_FR-1:0]  fr_cnt,
    input  logic             fr_tog,
    output logic [W_FR-1:0]  fi_val,
    output logic [W_LDP-1:0] ldp_val,
    output logic             fi_tog,
    output logic [REG_W-1:0] reg_rdata
);
    localparam int PAD_FI = LDP_LSB - W_FR;
    localparam int PAD_FR = TOGGLE_BIT - W_FR;

    logic wr_int;
    logic wdata_unused;

    assign wr_int       = reg_we && (reg_addr == ADDR_INTERVAL) && !hc_reset;
    assign wdata_unused = ^reg_wdata[LDP_LSB-1:W_FR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fi_val  <= FI_RST;
            ldp_val <= LDP_RST;
            fi_tog  <= 1'b0;
        end else if (hc_reset) begin
            fi_val  <= FI_RST;
            ldp_val <= LDP_RST;
            fi_tog  <= 1'b0;
        end else if (wr_int) begin
            fi_val  <= reg_wdata[W_FR-1:0];
            ldp_val <= reg_wdata[LDP_LSB +: W_LDP];
            fi_tog  <= reg_wdata[TOGGLE_BIT];
        end
    end

    always_comb begin
        if (reg_addr == ADDR_INTERVAL)
            reg_rdata = {fi_tog, ldp_val, {PAD_FI{1'b0}}, fi_val};
        else
            reg_rdata = {fr_tog, {PAD_FR{1'b0}}, fr_cnt};
    end
endmodule

// File: rtl/frm_ctrl.sv
module frm_ctrl
    import frm_pkg::*;
#(
    parameter int W_FR = FR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hc_reset,
    input  logic            op_enter,
    input  logic            bit_tick,
    input  logic [W_FR-1:0] fi_val,
    input  logic            fi_tog,
    output logic [W_FR-1:0] fr_cnt,
    output logic            fr_tog,
    output logic            sof_pulse,
    output logic            budget_load
);
    localparam logic [W_FR-1:0] ONE = W_FR'(1);

    frm_state_e state_q, state_d;
    logic counting;
    logic at_zero;
    logic wrap;

    // state register process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (op_enter) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HALT;
        endcase
        if (hc_reset) state_d = ST_HALT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // output decode process
    always_comb begin
        counting = 1'b0;
        unique case (state_q)
            ST_HALT: counting = 1'b0;
            ST_RUN:  counting = bit_tick && !op_enter && !hc_reset;
            default: counting = 1'b0;
        endcase
    end

    assign at_zero     = (fr_cnt == '0);
    assign wrap        = counting && at_zero;
    assign budget_load = (op_enter && !hc_reset) || wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_cnt    <= '0;
            fr_tog    <= 1'b0;
            sof_pulse <= 1'b0;
        end else if (hc_reset) begin
            fr_cnt    <= '0;
            fr_tog    <= 1'b0;
            sof_pulse <= 1'b0;
        end else begin
            sof_pulse <= wrap;
            if (op_enter) begin
                fr_cnt <= fi_val;
            end else if (wrap) begin
                fr_cnt <= fi_val;
            end else if (counting) begin
                fr_cnt <= fr_cnt - ONE;
                if (fr_cnt == ONE) fr_tog <= fi_tog;
            end
        end
    end
endmodule

// File: rtl/frm_budget.sv
module frm_budget
    import frm_pkg::*;
#(
    parameter int W_LDP = LDP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hc_reset,
    input  logic             load,
    input  logic [W_LDP-1:0] load_val,
    input  logic             bit_tick,
    output logic [W_LDP-1:0] budget
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        budget <= '0;
        else if (hc_reset)                 budget <= '0;
        else if (load)                     budget <= load_val;
        else if (bit_tick && budget != '0) budget <= budget - W_LDP'(1);
    end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import frm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hc_reset,
    input  logic              bit_tick,
    input  logic              op_enter,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sof_pulse,
    output logic [LDP_W-1:0]  budget_cnt
);
    logic [FR_W-1:0]  fi_val;
    logic [LDP_W-1:0] ldp_val;
    logic             fi_tog;
    logic [FR_W-1:0]  fr_cnt;
    logic             fr_tog;
    logic             budget_load;

    frm_regs #(.W_FR(FR_W), .W_LDP(LDP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .fr_cnt(fr_cnt), .fr_tog(fr_tog),
        .fi_val(fi_val), .ldp_val(ldp_val), .fi_tog(fi_tog),
        .reg_rdata(reg_rdata)
    );

    frm_ctrl #(.W_FR(FR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset),
        .op_enter(op_enter), .bit_tick(bit_tick),
        .fi_val(fi_val), .fi_tog(fi_tog),
        .fr_cnt(fr_cnt), .fr_tog(fr_tog),
        .sof_pulse(sof_pulse), .budget_load(budget_load)
    );

    frm_budget #(.W_LDP(LDP_W)) u_budget (
        .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset),
        .load(budget_load), .load_val(ldp_val),
        .bit_tick(bit_tick), .budget(budget_cnt)
    );
endmodule

// File: rtl/frm_timer_chk.sv
module frm_timer_chk
    import frm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hc_reset,
    input logic             bit_tick,
    input logic             op_enter,
    input logic             reg_we,
    input logic             reg_addr,
    input logic [FR_W-1:0]  fi_val,
    input logic [FR_W-1:0]  fr_cnt,
    input logic             sof_pulse,
    input logic [LDP_W-1:0] budget_cnt
);
    // R5
    sof_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> ($past(bit_tick) && $past(fr_cnt) == '0 && fr_cnt == $past(fi_val)));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_tick && fr_cnt != '0 && !op_enter && !hc_reset) |-> fr_cnt == $past(fr_cnt) - FR_W'(1));

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bit_tick && !op_enter && !hc_reset) |-> $stable(fr_cnt));

    // R8
    remain_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we && reg_addr == ADDR_REMAIN && !bit_tick && !op_enter && !hc_reset) |-> $stable(fr_cnt));

    // R9
    hc_reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hc_reset) |-> (fi_val == FI_NOMINAL && fr_cnt == '0 && budget_cnt == '0 && !sof_pulse));

    // R10
    budget_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_tick && !op_enter && !hc_reset) && !sof_pulse) |->
            budget_cnt == (($past(budget_cnt) == '0) ? '0 : $past(budget_cnt) - LDP_W'(1)));
endmodule

bind usb_frame_timer frm_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .bit_tick(bit_tick),
    .op_enter(op_enter), .reg_we(reg_we), .reg_addr(reg_addr),
    .fi_val(fi_val), .fr_cnt(fr_cnt), .sof_pulse(sof_pulse),
    .budget_cnt(budget_cnt)
);

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hc_reset = 1'b0;
    logic        bit_tick = 1'b0;
    logic        op_enter = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sof_pulse;
    logic [14:0] budget_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    int n_sof = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        logic [13:0] fr;
        logic [14:0] bud;
    } sof_exp_t;
    sof_exp_t exp_q[$];

    always #5 clk = ~clk;

    usb_frame_timer u_usb_frame_timer (
        .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .bit_tick(bit_tick),
        .op_enter(op_enter), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sof_pulse(sof_pulse), .budget_cnt(budget_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic expect_sof(input string req, input logic [13:0] fr, input logic [14:0] bud);
        sof_exp_t e;
        e.req = req; e.fr = fr; e.bud = bud;
        exp_q.push_back(e);
    endtask

    // monitor: pops an expected frame start for every SOF pulse observed
    always @(negedge clk) begin
        if (rst_n && sof_pulse) begin
            n_sof++;
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R5 unexpected sof_pulse: actual 1 expected 0");
            end else begin
                sof_exp_t e;
                logic [31:0] rd;
                e = exp_q.pop_front();
                rd = reg_rdata;
                chk(e.req, {17'b0, budget_cnt}, {17'b0, e.bud}, "budget at SOF");
                if (reg_addr == 1'b1) chk(e.req, {18'b0, rd[13:0]}, {18'b0, e.fr}, "count at SOF");
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick();
        bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; cyc();
        reg_we = 1'b0; reg_addr = 1'b1;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a; #1 d = reg_rdata; reg_addr = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int sof_before;
        reg_addr = 1'b1;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset values
        rd(1'b0, v); chk("R1", v, 32'h0000_2EDF, "interval reset");
        rd(1'b1, v); chk("R1", v, 32'h0000_0000, "remaining reset");

        // R2 halted: strobes do nothing
        sof_before = n_sof;
        repeat (3) tick();
        rd(1'b1, v); chk("R2", v, 32'h0, "count in HALT");
        chk("R2", n_sof - sof_before, 0, "sof count in HALT");

        // R3 program interval 5, budget 3, toggle 1, then enter operational
        wr(1'b0, 32'h8003_0005);
        op_enter = 1'b1; cyc(); op_enter = 1'b0;
        rd(1'b1, v); chk("R3", v, 32'h0000_0005, "count after entry");
        chk("R3", {17'b0, budget_cnt}, 32'd3, "budget after entry");
        chk("R3", n_sof - sof_before, 0, "no sof on entry");

        // R4 hold without strobe
        repeat (4) cyc();
        rd(1'b1, v); chk("R4", v, 32'h5, "count holds without strobe");

        // R4 / R10 decrement and saturation; R6 toggle copy at 1->0
        for (int i = 4; i >= 0; i--) begin
            tick();
            rd(1'b1, v);
            if (i == 0) chk("R6", v, 32'h8000_0000, "toggle copied at zero");
            else        chk("R4", v, i, "decrement");
            chk("R10", {17'b0, budget_cnt}, (i >= 2) ? (i - 2) : 0, "budget saturating");
        end

        // R5 wrap: reload 5, budget 3, SOF one cycle
        expect_sof("R5", 14'd5, 15'd3);
        tick();
        rd(1'b1, v); chk("R5", v[13:0], 32'd5, "reload value");
        cyc();
        chk("R5", {31'b0, sof_pulse}, 32'd0, "sof one cycle only");

        // R7 mid-frame write of new length 8, budget 7, toggle 0
        repeat (2) tick();
        wr(1'b0, 32'h0007_0008);
        rd(1'b1, v); chk("R7", v, 32'h8000_0003, "count unchanged by write");
        repeat (3) tick();
        rd(1'b1, v); chk("R6", v, 32'h0000_0000, "toggle cleared at zero");
        expect_sof("R7", 14'd8, 15'd7);
        tick();
        rd(1'b1, v); chk("R7", v, 32'h0000_0008, "new length at reload");

        // R8 writes to remaining ignored; reserved bits read zero
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); chk("R8", v, 32'h0000_0008, "remaining write ignored");
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); chk("R8", v, 32'hFFFF_3FFF, "interval reserved bits");

        // R9 host-controller reset
        hc_reset = 1'b1; cyc(); hc_reset = 1'b0;
        rd(1'b0, v); chk("R9", v, 32'h0000_2EDF, "interval after hc reset");
        rd(1'b1, v); chk("R9", v, 32'h0, "remaining after hc reset");
        chk("R9", {17'b0, budget_cnt}, 32'd0, "budget after hc reset");
        sof_before = n_sof;
        repeat (2) tick();
        rd(1'b1, v); chk("R9", v, 32'h0, "HALT after hc reset");
        chk("R9", n_sof - sof_before, 0, "no sof after hc reset");

        repeat (2) cyc();
        chk("R5", exp_q.size(), 0, "all expected SOFs seen");
        chk("R5", n_sof, 2, "total sof pulses");
        finish_run();
    end
endmodule